// File: doc/BRIEF.md
# Server Power-Up Sequencing Controller

This controller takes a server from standby power to a running state and back again. Once the housekeeping rail has been good for long enough, the controller releases the reset of the management logic and waits in standby. In standby the front-panel LED shows steady amber. A debounced press of the momentary power button, or a wake-on-LAN request, starts power-up. The controller first enables the bulk supplies and waits for the main rail. It then enables the fan and regulator stages one at a time, each after the previous stage reports power-good. Once every stage is up and the clock-stable flag is set, it releases system reset and turns the LED green.

Each wait has a bounded time. If a power-good or the clock-stable flag does not arrive in time, the controller turns the enables off in reverse order and parks in a fault state with the LED flashing amber. A button press in the running state shuts the system down in an orderly way. If the housekeeping rail fails in any state, the controller drops every output at once. A separate green health output shows whether both bulk supplies report OK.

All pins are plain level control and status signals. No data flows through the block, so it has no valid/ready interface and no back-pressure.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `mgmt_rst_n` stays low until `hk_pgood` has been high on HK_STABLE_CYC consecutive clock edges (default 16). A low cycle in between restarts the count.
- R2: Outside the housekeeping wait, the LED is steady amber in standby and while rails ramp up or down. It is green (`led_green`=1, `led_amber`=0) only while system reset is released. In the fault state, amber toggles every BLINK_HALF cycles (default 8). During the housekeeping wait, both LED outputs are 0.
- R3: In standby, either a button press or `wol_req`=1 starts power-up. A press is a debounced rising edge, so the button level must hold for at least DEBOUNCE_CYC cycles (default 4). Shorter pulses have no effect.
- R4: On a request, `bulk_en` rises first. `stage_en[0]` rises only after `main_pgood`. `stage_en[i]` rises only after `stage_pgood[i-1]`. A stage is never enabled while the stage below it, or `bulk_en` for stage 0, is off.
- R5: `sys_rst_n` rises only when every bit of `stage_en` is high and `clk_stable` is 1. It stays low while `clk_stable` is 0.
- R6: If the awaited power-good or `clk_stable` does not arrive within TIMEOUT_CYC cycles (default 64), the stages turn off highest-first, one per cycle, and then `bulk_en` turns off. The controller then enters the fault state, where `wol_req` is ignored. A button press in the fault state returns it to standby.
- R7: A button press while running drives `sys_rst_n` low first. The stages then turn off highest-first, `bulk_en` turns off last, and the controller returns to standby with `mgmt_rst_n` still high.
- R8: When `hk_pgood` is 0 at a clock edge, every output except `psu_health_led` is 0 after that edge, and the controller restarts the housekeeping wait.
- R9: `psu_health_led` is 1 exactly when both bits of `psu_ok` are 1, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset of the controller |
| hk_pgood | input | 1 | Housekeeping rail power-good |
| btn_raw | input | 1 | Raw momentary power-button level, asynchronous |
| wol_req | input | 1 | Wake-on-LAN request level |
| main_pgood | input | 1 | Main rail power-good |
| stage_pgood | input | NUM_STAGES | Power-good of each fan or regulator stage |
| clk_stable | input | 1 | Clocks programmed and stable |
| psu_ok | input | 2 | OK flag from each bulk supply |
| mgmt_rst_n | output | 1 | Management logic reset, active low |
| bulk_en | output | 1 | Bulk supply enable |
| stage_en | output | NUM_STAGES | Staged fan and regulator enables |
| sys_rst_n | output | 1 | System reset, active low |
| led_amber | output | 1 | Power LED amber drive |
| led_green | output | 1 | Power LED green drive |
| psu_health_led | output | 1 | Green supply-health indicator |

## Verification
The bound assertions check the rail ordering on every cycle: a stage is never on without the stage below it or without bulk. They also check that system reset is released only with all stages on and the clock stable, that the two LED colours never light together, and that housekeeping loss clears every output on the next edge. Other behaviours need a sequence of stimulus and can only be shown by the bench scenarios. These are the glitch that restarts the housekeeping count, button debouncing, wake-on-LAN start-up, the timeout into the fault state, amber flashing, recovery from the fault state, and the orderly shutdown back to standby.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [3:0] {
    S_HK_WAIT,
    S_STANDBY,
    S_BULK,
    S_STAGE,
    S_CLKWAIT,
    S_RUN,
    S_SHUT,
    S_FDOWN,
    S_FAULT
  } pwr_state_e;
endpackage

// File: rtl/pwr_btn_filter.sv
module pwr_btn_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic press
);
  localparam int CW = $clog2(DEBOUNCE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   stable_q;
  logic                   stable_prev_q;
  logic [CW-1:0]          cnt_q;

  // synchroniser chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
  end

  // level must differ from the accepted level for DEBOUNCE_CYC cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q         <= '0;
      stable_q      <= 1'b0;
      stable_prev_q <= 1'b0;
    end else begin
      stable_prev_q <= stable_q;
      if (sync_q[SYNC_STAGES-1] == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEBOUNCE_CYC - 1)) begin
        cnt_q    <= '0;
        stable_q <= sync_q[SYNC_STAGES-1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press = stable_q && !stable_prev_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int NUM_STAGES    = 3,
  parameter int HK_STABLE_CYC = 16,
  parameter int TIMEOUT_CYC   = 64,
  localparam int LW = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hk_pgood,
  input  logic                  press,
  input  logic                  wol_req,
  input  logic                  main_pgood,
  input  logic [NUM_STAGES-1:0] stage_pgood,
  input  logic                  clk_stable,
  output pwr_state_e            state,
  output logic [LW-1:0]         level,
  output logic                  mgmt_rst_n,
  output logic                  bulk_en,
  output logic                  sys_rst_n
);
  localparam int HW = $clog2(HK_STABLE_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  pwr_state_e    st_q, st_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [HW-1:0] hk_q, hk_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          mgmt_q, mgmt_d, bulk_q, bulk_d, sys_q, sys_d;
  logic          cur_pg, timed_out;

  always_comb begin
    cur_pg = 1'b0;
    for (int i = 0; i < NUM_STAGES; i++)
      if (lvl_q == LW'(i + 1)) cur_pg = stage_pgood[i];
  end

  assign timed_out = (tmr_q == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    hk_d   = hk_q;
    tmr_d  = tmr_q;
    mgmt_d = mgmt_q;
    bulk_d = bulk_q;
    sys_d  = sys_q;
    case (st_q)
      S_HK_WAIT: begin
        if (!hk_pgood) hk_d = '0;
        else if (hk_q == HW'(HK_STABLE_CYC - 1)) begin
          hk_d   = '0;
          mgmt_d = 1'b1;
          st_d   = S_STANDBY;
        end else hk_d = hk_q + 1'b1;
      end
      S_STANDBY: begin
        if (press || wol_req) begin
          bulk_d = 1'b1;
          tmr_d  = '0;
          st_d   = S_BULK;
        end
      end
      S_BULK: begin
        if (main_pgood) begin
          lvl_d = LW'(1);
          tmr_d = '0;
          st_d  = S_STAGE;
        end else if (timed_out) st_d = S_FDOWN;
        else tmr_d = tmr_q + 1'b1;
      end
      S_STAGE: begin
        if (cur_pg) begin
          tmr_d = '0;
          if (lvl_q == LW'(NUM_STAGES)) st_d = S_CLKWAIT;
          else lvl_d = lvl_q + 1'b1;
        end else if (timed_out) st_d = S_FDOWN;
        else tmr_d = tmr_q + 1'b1;
      end
      S_CLKWAIT: begin
        if (clk_stable) begin
          sys_d = 1'b1;
          st_d  = S_RUN;
        end else if (timed_out) st_d = S_FDOWN;
        else tmr_d = tmr_q + 1'b1;
      end
      S_RUN: begin
        if (press) begin
          sys_d = 1'b0;
          st_d  = S_SHUT;
        end
      end
      S_SHUT, S_FDOWN: begin
        if (lvl_q != '0) lvl_d = lvl_q - 1'b1;
        else begin
          bulk_d = 1'b0;
          st_d   = (st_q == S_SHUT) ? S_STANDBY : S_FAULT;
        end
      end
      S_FAULT: begin
        if (press) st_d = S_STANDBY;
      end
      default: st_d = S_HK_WAIT;
    endcase
    // housekeeping loss overrides everything
    if (!hk_pgood) begin
      st_d   = S_HK_WAIT;
      lvl_d  = '0;
      hk_d   = '0;
      tmr_d  = '0;
      mgmt_d = 1'b0;
      bulk_d = 1'b0;
      sys_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_HK_WAIT;
      lvl_q  <= '0;
      hk_q   <= '0;
      tmr_q  <= '0;
      mgmt_q <= 1'b0;
      bulk_q <= 1'b0;
      sys_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      hk_q   <= hk_d;
      tmr_q  <= tmr_d;
      mgmt_q <= mgmt_d;
      bulk_q <= bulk_d;
      sys_q  <= sys_d;
    end
  end

  assign state      = st_q;
  assign level      = lvl_q;
  assign mgmt_rst_n = mgmt_q;
  assign bulk_en    = bulk_q;
  assign sys_rst_n  = sys_q;
endmodule

// File: rtl/pwr_led_drive.sv
module pwr_led_drive
  import pwr_seq_pkg::*;
#(
  parameter int BLINK_HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  output logic       led_amber,
  output logic       led_green
);
  localparam int BW = $clog2(BLINK_HALF + 1);

  logic [BW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (state != S_FAULT) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == BW'(BLINK_HALF - 1)) begin
      cnt_q   <= '0;
      phase_q <= !phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    led_green = 1'b0;
    led_amber = 1'b0;
    case (state)
      S_HK_WAIT: ;
      S_RUN:     led_green = 1'b1;
      S_FAULT:   led_amber = phase_q;
      default:   led_amber = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_STAGES    = 3,
  parameter int HK_STABLE_CYC = 16,
  parameter int DEBOUNCE_CYC  = 4,
  parameter int TIMEOUT_CYC   = 64,
  parameter int BLINK_HALF    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hk_pgood,
  input  logic                  btn_raw,
  input  logic                  wol_req,
  input  logic                  main_pgood,
  input  logic [NUM_STAGES-1:0] stage_pgood,
  input  logic                  clk_stable,
  input  logic [1:0]            psu_ok,
  output logic                  mgmt_rst_n,
  output logic                  bulk_en,
  output logic [NUM_STAGES-1:0] stage_en,
  output logic                  sys_rst_n,
  output logic                  led_amber,
  output logic                  led_green,
  output logic                  psu_health_led
);
  localparam int LW = $clog2(NUM_STAGES + 1);

  logic          press;
  pwr_state_e    state;
  logic [LW-1:0] level;

  pwr_btn_filter #(
    .SYNC_STAGES (2),
    .DEBOUNCE_CYC(DEBOUNCE_CYC)
  ) u_btn (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn_raw(btn_raw),
    .press  (press)
  );

  pwr_seq_fsm #(
    .NUM_STAGES   (NUM_STAGES),
    .HK_STABLE_CYC(HK_STABLE_CYC),
    .TIMEOUT_CYC  (TIMEOUT_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hk_pgood   (hk_pgood),
    .press      (press),
    .wol_req    (wol_req),
    .main_pgood (main_pgood),
    .stage_pgood(stage_pgood),
    .clk_stable (clk_stable),
    .state      (state),
    .level      (level),
    .mgmt_rst_n (mgmt_rst_n),
    .bulk_en    (bulk_en),
    .sys_rst_n  (sys_rst_n)
  );

  pwr_led_drive #(
    .BLINK_HALF(BLINK_HALF)
  ) u_led (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .led_amber(led_amber),
    .led_green(led_green)
  );

  // thermometer decode: stage g is on while the level is above g
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    assign stage_en[g] = (level > LW'(g));
  end

  assign psu_health_led = &psu_ok;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int NUM_STAGES = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  hk_pgood,
  input logic                  clk_stable,
  input logic                  mgmt_rst_n,
  input logic                  bulk_en,
  input logic [NUM_STAGES-1:0] stage_en,
  input logic                  sys_rst_n,
  input logic                  led_amber,
  input logic                  led_green
);
  // R8
  hk_loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hk_pgood |=> (!mgmt_rst_n && !bulk_en && stage_en == '0 && !sys_rst_n
                   && !led_amber && !led_green));

  // R1
  mgmt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mgmt_rst_n) |-> $past(hk_pgood));

  // R4
  bulk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bulk_en) |-> ($past(mgmt_rst_n) && stage_en == '0));

  // R4
  stage0_needs_bulk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en[0] |-> bulk_en);

  for (genvar i = 1; i < NUM_STAGES; i++) begin : g_ord
    // R4
    stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_en[i] |-> stage_en[i-1]);
  end

  // R5
  sys_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(clk_stable));

  // R7
  run_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |-> (bulk_en && stage_en == '1));

  // R2
  led_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_green && led_amber));

  // R2
  green_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_green |-> sys_rst_n);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hk_pgood  (hk_pgood),
  .clk_stable(clk_stable),
  .mgmt_rst_n(mgmt_rst_n),
  .bulk_en   (bulk_en),
  .stage_en  (stage_en),
  .sys_rst_n (sys_rst_n),
  .led_amber (led_amber),
  .led_green (led_green)
);

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
  localparam int NS = 3;
  localparam int BH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hk_pgood = 1'b0, btn_raw = 1'b0, wol_req = 1'b0, clk_stable = 1'b0;
  logic main_pgood = 1'b0;
  logic [NS-1:0] stage_pgood = '0;
  logic [1:0] psu_ok = 2'b11;
  logic main_ok = 1'b1;
  logic [NS-1:0] stage_ok = '1;
  logic mgmt_rst_n, bulk_en, sys_rst_n, led_amber, led_green, psu_health_led;
  logic [NS-1:0] stage_en;

  int checks = 0;
  int errors = 0;
  int mon_err = 0;
  logic prev_sys = 1'b0;

  always #4 clk = !clk;

  pwr_seq_ctrl #(.NUM_STAGES(NS), .BLINK_HALF(BH)) uut (
    .clk(clk), .rst_n(rst_n), .hk_pgood(hk_pgood), .btn_raw(btn_raw),
    .wol_req(wol_req), .main_pgood(main_pgood), .stage_pgood(stage_pgood),
    .clk_stable(clk_stable), .psu_ok(psu_ok), .mgmt_rst_n(mgmt_rst_n),
    .bulk_en(bulk_en), .stage_en(stage_en), .sys_rst_n(sys_rst_n),
    .led_amber(led_amber), .led_green(led_green), .psu_health_led(psu_health_led)
  );

  // rail models: power-good follows enable one cycle later when allowed
  always_ff @(posedge clk) begin
    main_pgood  <= bulk_en & main_ok;
    stage_pgood <= stage_en & stage_ok;
  end

  // ordering monitor (R4, R5, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (stage_en[0] && !bulk_en) mon_err++;
      for (int i = 1; i < NS; i++) if (stage_en[i] && !stage_en[i-1]) mon_err++;
      if (sys_rst_n && stage_en != '1) mon_err++;
      if (sys_rst_n && !prev_sys && !clk_stable) mon_err++;
      prev_sys <= sys_rst_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_btn();
    btn_raw = 1'b1; cyc(10);
    btn_raw = 1'b0; cyc(10);
  endtask

  task automatic wait_run();
    for (int i = 0; i < 600 && !sys_rst_n; i++) @(negedge clk);
  endtask

  task automatic wait_bulk_off();
    for (int i = 0; i < 600 && bulk_en; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(2);
    chk(!mgmt_rst_n && !bulk_en && stage_en == '0 && !sys_rst_n, "R8 reset outputs",
        {mgmt_rst_n, bulk_en, sys_rst_n}, 0);
    chk(!led_amber && !led_green, "R2 leds off in hk wait", {led_amber, led_green}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_hk_glitch();
    hk_pgood = 1'b1; cyc(10);
    hk_pgood = 1'b0; cyc(1);
    hk_pgood = 1'b1; cyc(10);
    chk(!mgmt_rst_n, "R1 glitch restarts count", mgmt_rst_n, 0);
    cyc(10);
    chk(mgmt_rst_n, "R1 release after stable", mgmt_rst_n, 1);
    chk(led_amber && !led_green, "R2 amber in standby", {led_amber, led_green}, 2);
  endtask

  task automatic t_btn_glitch();
    btn_raw = 1'b1; cyc(2);
    btn_raw = 1'b0; cyc(30);
    chk(!bulk_en, "R3 short pulse ignored", bulk_en, 0);
  endtask

  task automatic t_health();
    logic [1:0] v;
    for (int k = 0; k < 4; k++) begin
      v = 2'(k);
      psu_ok = v; #1;
      chk(psu_health_led == (v == 2'b11), "R9 health and", psu_health_led, int'(v == 2'b11));
    end
    psu_ok = 2'b11;
  endtask

  task automatic t_btn_powerup();
    mon_err = 0;
    clk_stable = 1'b1;
    press_btn();
    wait_run();
    chk(sys_rst_n, "R3 button starts power-up", sys_rst_n, 1);
    chk(stage_en == '1 && bulk_en, "R4 all stages on", int'(stage_en), (1 << NS) - 1);
    chk(led_green && !led_amber, "R2 green in run", {led_amber, led_green}, 1);
    chk(mon_err == 0, "R4 R5 ordering during power-up", mon_err, 0);
  endtask

  task automatic t_shutdown();
    mon_err = 0;
    press_btn();
    wait_bulk_off();
    cyc(2);
    chk(!bulk_en && stage_en == '0 && !sys_rst_n, "R7 rails off after press",
        int'(stage_en), 0);
    chk(mon_err == 0, "R7 reverse shutdown order", mon_err, 0);
    chk(mgmt_rst_n && led_amber, "R7 back in standby", {mgmt_rst_n, led_amber}, 3);
  endtask

  task automatic t_wol_clkwait();
    mon_err = 0;
    clk_stable = 1'b0;
    wol_req = 1'b1; cyc(1); wol_req = 1'b0;
    for (int i = 0; i < 300 && stage_en != '1; i++) @(negedge clk);
    cyc(10);
    chk(stage_en == '1, "R3 wake request starts power-up", int'(stage_en), (1 << NS) - 1);
    chk(!sys_rst_n, "R5 held while clock unstable", sys_rst_n, 0);
    clk_stable = 1'b1;
    cyc(4);
    chk(sys_rst_n, "R5 release with clock stable", sys_rst_n, 1);
    chk(mon_err == 0, "R5 ordering", mon_err, 0);
  endtask

  task automatic t_fault();
    int toggles;
    logic last;
    stage_ok = '1; stage_ok[1] = 1'b0;
    press_btn();
    for (int i = 0; i < 50 && !bulk_en; i++) @(negedge clk);
    wait_bulk_off();
    cyc(2);
    chk(!bulk_en && stage_en == '0 && !sys_rst_n, "R6 timeout drops rails",
        int'(stage_en), 0);
    toggles = 0; last = led_amber;
    for (int i = 0; i < 4 * BH; i++) begin
      @(negedge clk);
      if (led_amber != last) toggles++;
      last = led_amber;
    end
    chk(toggles >= 3 && !led_green, "R2 amber flashes in fault", toggles, 4);
    stage_ok = '1;
    wol_req = 1'b1; cyc(1); wol_req = 1'b0; cyc(20);
    chk(!bulk_en, "R6 wake ignored in fault", bulk_en, 0);
    press_btn();
    toggles = 0;
    for (int i = 0; i < 3 * BH; i++) begin
      @(negedge clk);
      if (!led_amber) toggles++;
    end
    chk(toggles == 0 && !bulk_en, "R6 press returns to standby", toggles, 0);
  endtask

  task automatic t_hk_loss();
    t_btn_powerup();
    hk_pgood = 1'b0; cyc(1);
    chk(!mgmt_rst_n && !bulk_en && stage_en == '0 && !sys_rst_n && !led_green && !led_amber,
        "R8 hk loss clears outputs", {mgmt_rst_n, bulk_en, sys_rst_n, led_green}, 0);
    chk(psu_health_led, "R9 health unaffected", psu_health_led, 1);
    hk_pgood = 1'b1; cyc(20);
    chk(mgmt_rst_n && !bulk_en, "R1 standby after hk returns", mgmt_rst_n, 1);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    t_reset();
    t_hk_glitch();
    t_btn_glitch();
    t_health();
    t_btn_powerup();
    t_shutdown();
    t_wol_clkwait();
    t_shutdown();
    t_fault();
    t_hk_loss();
    finish_sim();
  end
endmodule